// File: doc/BRIEF.md
# Multi-lane PCS receive frame controller

This block is the frame-tracking stage on the receive side of a four-lane physical coding sublayer. Each clock it accepts one column of decoded code-groups. A column holds one byte per lane, a control flag per lane and a code-error flag per lane. The block rebuilds a 32-bit data word with four control bits for the MAC side. While idle it emits idle columns. It opens a frame on a well-formed start column, passes data columns through, and closes the frame on a terminate character.

To close a frame correctly the block needs one column of lookahead. It holds the current column for one clock, so the column that follows is visible when the held one is translated. Before the terminate character is passed on, every lane after it and the whole next column must be idle-class control code-groups. If any of them is not, the terminate is turned into an error character, so the MAC drops the frame. An unexpected control character inside a frame aborts the frame, and nothing is passed on until the next valid start. A code error on a lane inside a frame poisons only that lane. Sequence ordered sets seen between frames are passed through in their own mode, and no end check is run for them.

Input control codes: start 0xFB, terminate 0xFD, error 0xFE, sequence 0x9C. The idle class is 0xBC, 0x1C and 0x7C. Lane 0 is byte [7:0], and lane n is byte [8n+7:8n]. On the output side, idle is 0x07 and every control lane has its control bit set.

Top module: `pcsrx_frame_ctrl`

## Requirements
- R1: Inside a frame, a column of four plain data lanes (control and code-error flags clear) is output unchanged with all control bits 0.
- R2: A frame opens only from idle or sequence mode, and only on a column with 0xFB as control in lane 0, no code error, and plain data in lanes 1 to 3. That column is output unchanged (control bits 0001).
- R3: Outside a frame, every column that is not a valid start or sequence column is output as an all-idle column (0x07 on every lane, control bits 1111). This covers a 0xFB in lanes 1 to 3, stray data, and terminate or error characters.
- R4: Inside a frame, a column whose first non-data lane is a clean control 0xFD closes the frame. Lanes before the terminate pass as data, the terminate lane is output as control 0xFD, and later lanes are output as control 0x07. This holds when every later lane of that column and every lane of the next column is idle-class (control 0xBC, 0x1C or 0x7C without code error).
- R5: In the R4 case, if any later lane of the terminate column, or any lane of the next column, is not idle-class, the terminate lane is output as control 0xFE instead. All other lanes are output as in R4.
- R6: Outside a frame, a column with clean control 0x9C in lane 0 and plain data in lanes 1 to 3 is output unchanged. A valid start in the next column is still accepted.
- R7: Inside a frame, a column that holds a clean control lane and is not an R4 terminate column aborts the frame. Plain data lanes pass, every other lane is output as control 0xFE, and the following columns obey R3.
- R8: Inside a frame, a lane with its code-error flag set is output as control 0xFE. The frame continues.
- R9: While the synchronous clear is high or the lane-alignment input is low, the next output column is all-idle and any open frame is dropped.
- R10: After the asynchronous reset, the output is all-idle.
- R11: A column presented before rising edge k is translated and shown on the outputs after rising edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| srst | input | 1 | Synchronous clear to idle |
| lanes_aligned | input | 1 | High when the four lanes are deskewed; low forces idle |
| in_data | input | 32 | Decoded bytes, lane 0 in [7:0] |
| in_ctrl | input | 4 | Per-lane control flag |
| in_cerr | input | 4 | Per-lane code-error flag |
| out_data | output | 32 | Translated bytes, lane 0 in [7:0] |
| out_ctrl | output | 4 | Per-lane control bit of the output |

## Verification
A wrong frame state shows up at the ports no later than two columns after the column that triggered it. A machine wrongly left inside a frame lets data lanes leak out where all-idle columns are expected. A machine wrongly left idle turns a frame's data into idle columns. A wrong end-check decision shows as 0xFD where 0xFE was due, or the other way round, in the column that closes the frame. A lost or spurious lookahead register would shift every output by one column, so the bench compares each output column against a behavioural model on every clock.

// File: rtl/pcsrx_pkg.sv
package pcsrx_pkg;

  localparam int unsigned CODE_W = 8;

  // input-side control code-groups
  localparam logic [CODE_W-1:0] C_START  = 8'hFB;
  localparam logic [CODE_W-1:0] C_TERM   = 8'hFD;
  localparam logic [CODE_W-1:0] C_ERR    = 8'hFE;
  localparam logic [CODE_W-1:0] C_SEQ    = 8'h9C;
  localparam logic [CODE_W-1:0] C_IDL_K  = 8'hBC;
  localparam logic [CODE_W-1:0] C_IDL_R  = 8'h1C;
  localparam logic [CODE_W-1:0] C_IDL_A  = 8'h7C;

  // output-side idle
  localparam logic [CODE_W-1:0] C_OUT_IDLE = 8'h07;

  typedef enum logic [2:0] {
    ST_RECV   = 3'd0,
    ST_DSTART = 3'd1,
    ST_DOTHER = 3'd2,
    ST_SEQ    = 3'd3,
    ST_TERM   = 3'd4
  } rx_st_e;

endpackage

// File: rtl/pcsrx_lane_class.sv
module pcsrx_lane_class
  import pcsrx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [CODE_W*LANES-1:0] col_d,
  input  logic [LANES-1:0]        col_c,
  input  logic [LANES-1:0]        col_e,
  output logic [LANES-1:0]        is_data,
  output logic [LANES-1:0]        is_ctl,
  output logic [LANES-1:0]        is_term,
  output logic [LANES-1:0]        is_idle,
  output logic                    col_start,
  output logic                    col_seq
);

  logic [CODE_W-1:0] lane_b [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_b[i]  = col_d[CODE_W*i +: CODE_W];
    assign is_data[i] = ~col_c[i] & ~col_e[i];
    assign is_ctl[i]  =  col_c[i] & ~col_e[i];
    assign is_term[i] = is_ctl[i] & (lane_b[i] == C_TERM);
    assign is_idle[i] = is_ctl[i] & ((lane_b[i] == C_IDL_K) |
                                     (lane_b[i] == C_IDL_R) |
                                     (lane_b[i] == C_IDL_A));
  end

  // opening columns need lane 0 control and data on every other lane
  assign col_start = is_ctl[0] & (lane_b[0] == C_START) & (&is_data[LANES-1:1]);
  assign col_seq   = is_ctl[0] & (lane_b[0] == C_SEQ)   & (&is_data[LANES-1:1]);

endmodule

// File: rtl/pcsrx_col_reg.sv
module pcsrx_col_reg
  import pcsrx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [CODE_W*LANES-1:0] nxt_d,
  input  logic [LANES-1:0]        nxt_c,
  input  logic [LANES-1:0]        nxt_data,
  input  logic [LANES-1:0]        nxt_ctl,
  input  logic [LANES-1:0]        nxt_term,
  input  logic [LANES-1:0]        nxt_idle,
  input  logic                    nxt_start,
  input  logic                    nxt_seq,
  output logic [CODE_W*LANES-1:0] cur_d,
  output logic [LANES-1:0]        cur_c,
  output logic [LANES-1:0]        cur_data,
  output logic [LANES-1:0]        cur_ctl,
  output logic [LANES-1:0]        cur_term,
  output logic [LANES-1:0]        cur_idle,
  output logic                    cur_start,
  output logic                    cur_seq
);

  localparam logic [CODE_W*LANES-1:0] IDLE_IN = {LANES{C_IDL_K}};

  // held column: an idle column while reset or cleared
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_d     <= IDLE_IN;
      cur_c     <= '1;
      cur_data  <= '0;
      cur_ctl   <= '1;
      cur_term  <= '0;
      cur_idle  <= '1;
      cur_start <= 1'b0;
      cur_seq   <= 1'b0;
    end else if (clr) begin
      cur_d     <= IDLE_IN;
      cur_c     <= '1;
      cur_data  <= '0;
      cur_ctl   <= '1;
      cur_term  <= '0;
      cur_idle  <= '1;
      cur_start <= 1'b0;
      cur_seq   <= 1'b0;
    end else begin
      cur_d     <= nxt_d;
      cur_c     <= nxt_c;
      cur_data  <= nxt_data;
      cur_ctl   <= nxt_ctl;
      cur_term  <= nxt_term;
      cur_idle  <= nxt_idle;
      cur_start <= nxt_start;
      cur_seq   <= nxt_seq;
    end
  end

endmodule

// File: rtl/pcsrx_fsm.sv
module pcsrx_fsm
  import pcsrx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [CODE_W*LANES-1:0] cur_d,
  input  logic [LANES-1:0]        cur_c,
  input  logic [LANES-1:0]        cur_data,
  input  logic [LANES-1:0]        cur_ctl,
  input  logic [LANES-1:0]        cur_term,
  input  logic [LANES-1:0]        cur_idle,
  input  logic                    cur_start,
  input  logic                    cur_seq,
  input  logic [LANES-1:0]        look_idle,
  output logic [CODE_W*LANES-1:0] out_d,
  output logic [LANES-1:0]        out_c,
  output rx_st_e                  st
);

  localparam int unsigned DW = CODE_W * LANES;
  localparam logic [DW-1:0] IDLE_OUT = {LANES{C_OUT_IDLE}};

  rx_st_e          st_nx;
  logic [DW-1:0]   od_nx;
  logic [LANES-1:0] oc_nx;

  logic [LANES-1:0] pre_t, at_t, post_t;
  logic             t_seen, t_blocked, tail_ok, in_frame;

  // locate the first terminate that only data lanes precede
  always_comb begin
    pre_t     = '0;
    at_t      = '0;
    post_t    = '0;
    t_seen    = 1'b0;
    t_blocked = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (t_seen) begin
        post_t[i] = 1'b1;
      end else if (!t_blocked) begin
        if (cur_term[i]) begin
          at_t[i] = 1'b1;
          t_seen  = 1'b1;
        end else if (cur_data[i]) begin
          pre_t[i] = 1'b1;
        end else begin
          t_blocked = 1'b1;
        end
      end
    end
    tail_ok = (&look_idle) & ~(|(post_t & ~cur_idle));
  end

  assign in_frame = (st == ST_DSTART) || (st == ST_DOTHER);

  // next state and next output column
  always_comb begin
    st_nx = st;
    od_nx = IDLE_OUT;
    oc_nx = '1;
    if (clr) begin
      st_nx = ST_RECV;
    end else if (!in_frame) begin
      if (cur_start) begin
        st_nx = ST_DSTART;
        od_nx = cur_d;
        oc_nx = cur_c;
      end else if (cur_seq) begin
        st_nx = ST_SEQ;
        od_nx = cur_d;
        oc_nx = cur_c;
      end else begin
        st_nx = ST_RECV;
      end
    end else if (t_seen) begin
      st_nx = ST_TERM;
      for (int i = 0; i < LANES; i++) begin
        if (pre_t[i]) begin
          od_nx[CODE_W*i +: CODE_W] = cur_d[CODE_W*i +: CODE_W];
          oc_nx[i]                  = 1'b0;
        end else if (at_t[i]) begin
          od_nx[CODE_W*i +: CODE_W] = tail_ok ? C_TERM : C_ERR;
        end
      end
    end else begin
      st_nx = (|cur_ctl) ? ST_RECV : ST_DOTHER;
      for (int i = 0; i < LANES; i++) begin
        if (cur_data[i]) begin
          od_nx[CODE_W*i +: CODE_W] = cur_d[CODE_W*i +: CODE_W];
          oc_nx[i]                  = 1'b0;
        end else begin
          od_nx[CODE_W*i +: CODE_W] = C_ERR;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_RECV;
      out_d <= IDLE_OUT;
      out_c <= '1;
    end else begin
      st    <= st_nx;
      out_d <= od_nx;
      out_c <= oc_nx;
    end
  end

endmodule

// File: rtl/pcsrx_frame_ctrl.sv
module pcsrx_frame_ctrl
  import pcsrx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    srst,
  input  logic                    lanes_aligned,
  input  logic [CODE_W*LANES-1:0] in_data,
  input  logic [LANES-1:0]        in_ctrl,
  input  logic [LANES-1:0]        in_cerr,
  output logic [CODE_W*LANES-1:0] out_data,
  output logic [LANES-1:0]        out_ctrl
);

  localparam int unsigned DW = CODE_W * LANES;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic clr;
  assign clr = srst | ~lanes_aligned;

  logic [LANES-1:0] n_data, n_ctl, n_term, n_idle;
  logic             n_start, n_seq;

  pcsrx_lane_class #(.LANES(LANES)) u_class (
    .col_d     (in_data),
    .col_c     (in_ctrl),
    .col_e     (in_cerr),
    .is_data   (n_data),
    .is_ctl    (n_ctl),
    .is_term   (n_term),
    .is_idle   (n_idle),
    .col_start (n_start),
    .col_seq   (n_seq)
  );

  logic [DW-1:0]    c_d;
  logic [LANES-1:0] c_c, c_data, c_ctl, c_term, c_idle;
  logic             c_start, c_seq;

  pcsrx_col_reg #(.LANES(LANES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (clr),
    .nxt_d     (in_data),
    .nxt_c     (in_ctrl),
    .nxt_data  (n_data),
    .nxt_ctl   (n_ctl),
    .nxt_term  (n_term),
    .nxt_idle  (n_idle),
    .nxt_start (n_start),
    .nxt_seq   (n_seq),
    .cur_d     (c_d),
    .cur_c     (c_c),
    .cur_data  (c_data),
    .cur_ctl   (c_ctl),
    .cur_term  (c_term),
    .cur_idle  (c_idle),
    .cur_start (c_start),
    .cur_seq   (c_seq)
  );

  rx_st_e st;

  pcsrx_fsm #(.LANES(LANES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (clr),
    .cur_d     (c_d),
    .cur_c     (c_c),
    .cur_data  (c_data),
    .cur_ctl   (c_ctl),
    .cur_term  (c_term),
    .cur_idle  (c_idle),
    .cur_start (c_start),
    .cur_seq   (c_seq),
    .look_idle (n_idle),
    .out_d     (out_data),
    .out_c     (out_ctrl),
    .st        (st)
  );

endmodule

// File: rtl/pcsrx_frame_ctrl_chk.sv
module pcsrx_frame_ctrl_chk
  import pcsrx_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    srst,
  input logic                    lanes_aligned,
  input logic [CODE_W*LANES-1:0] out_data,
  input logic [LANES-1:0]        out_ctrl,
  input rx_st_e                  st
);

  localparam logic [CODE_W*LANES-1:0] IDLE_OUT = {LANES{C_OUT_IDLE}};

  p_idle_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (srst || !lanes_aligned) |=> (out_ctrl == '1 && out_data == IDLE_OUT));

  p_quiet_outside_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECV && $past(st) != ST_DSTART && $past(st) != ST_DOTHER)
      |-> (out_ctrl == '1));

  for (genvar j = 1; j < LANES; j++) begin : g_start
    p_start_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_ctrl[j] && out_data[CODE_W*j +: CODE_W] == C_START));
  end

  for (genvar j = 0; j < LANES - 1; j++) begin : g_tail
    p_term_tail_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ctrl[j] && out_data[CODE_W*j +: CODE_W] == C_TERM)
        |-> (out_ctrl[j+1] && out_data[CODE_W*(j+1) +: CODE_W] == C_OUT_IDLE));
  end

endmodule

bind pcsrx_frame_ctrl pcsrx_frame_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .srst          (srst),
  .lanes_aligned (lanes_aligned),
  .out_data      (out_data),
  .out_ctrl      (out_ctrl),
  .st            (st)
);

// File: tb/sim_pcsrx_frame_ctrl.sv
`timescale 1ns/1ps
module sim_pcsrx_frame_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic        aligned = 1'b1;
  logic [31:0] in_d = {4{8'hBC}};
  logic [3:0]  in_c = 4'hF;
  logic [3:0]  in_e = 4'h0;
  logic [31:0] out_d;
  logic [3:0]  out_c;

  always #10 clk = ~clk;

  pcsrx_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .lanes_aligned(aligned),
    .in_data(in_d), .in_ctrl(in_c), .in_cerr(in_e),
    .out_data(out_d), .out_ctrl(out_c)
  );

  int n_run = 0;
  int n_fail = 0;

  // behavioural model: previous column, frame flag, pending expectation
  logic [31:0] m_hd = {4{8'hBC}};
  logic [3:0]  m_hc = 4'hF;
  logic [3:0]  m_he = 4'h0;
  bit          m_frame = 0;
  logic [31:0] x_d = {4{8'h07}};
  logic [3:0]  x_c = 4'hF;
  string       x_tag = "R10";

  function automatic bit idle_like(logic [7:0] b, logic c, logic e);
    return c && !e && (b == 8'hBC || b == 8'h1C || b == 8'h7C);
  endfunction

  task automatic check_out();
    n_run++;
    if (out_d !== x_d || out_c !== x_c) begin
      n_fail++;
      $display("FAIL %s: got %h/%b expected %h/%b", x_tag, out_d, out_c, x_d, x_c);
    end
  endtask

  task automatic model(logic [31:0] nd, logic [3:0] nc, logic [3:0] ne, bit al, bit sr);
    bit rest_data;
    int tpos;
    bit blocked, ok, anyctl;
    x_d = {4{8'h07}};
    x_c = 4'hF;
    if (sr || !al) begin
      x_tag = "R9";
      m_frame = 0;
      m_hd = {4{8'hBC}}; m_hc = 4'hF; m_he = 4'h0;
    end else begin
      if (!m_frame) begin
        rest_data = (m_hc[3:1] == 3'b000) && (m_he[3:1] == 3'b000);
        if (m_hc[0] && !m_he[0] && m_hd[7:0] == 8'hFB && rest_data) begin
          x_d = m_hd; x_c = m_hc; m_frame = 1; x_tag = "R2";
        end else if (m_hc[0] && !m_he[0] && m_hd[7:0] == 8'h9C && rest_data) begin
          x_d = m_hd; x_c = m_hc; x_tag = "R6";
        end else begin
          x_tag = "R3";
        end
      end else begin
        tpos = -1; blocked = 0;
        for (int i = 0; i < 4; i++) begin
          if (tpos < 0 && !blocked) begin
            if (m_hc[i] && !m_he[i] && m_hd[8*i +: 8] == 8'hFD) tpos = i;
            else if (m_hc[i] || m_he[i]) blocked = 1;
          end
        end
        if (tpos >= 0) begin
          ok = 1;
          for (int i = 0; i < 4; i++) begin
            if (i > tpos && !idle_like(m_hd[8*i +: 8], m_hc[i], m_he[i])) ok = 0;
            if (!idle_like(nd[8*i +: 8], nc[i], ne[i])) ok = 0;
          end
          for (int i = 0; i < 4; i++) begin
            if (i < tpos) begin x_d[8*i +: 8] = m_hd[8*i +: 8]; x_c[i] = 1'b0; end
            else if (i == tpos) x_d[8*i +: 8] = ok ? 8'hFD : 8'hFE;
          end
          m_frame = 0;
          x_tag = ok ? "R4" : "R5";
        end else begin
          anyctl = 0;
          for (int i = 0; i < 4; i++) begin
            if (m_hc[i] && !m_he[i]) anyctl = 1;
            if (!m_hc[i] && !m_he[i]) begin x_d[8*i +: 8] = m_hd[8*i +: 8]; x_c[i] = 1'b0; end
            else x_d[8*i +: 8] = 8'hFE;
          end
          if (anyctl) begin m_frame = 0; x_tag = "R7"; end
          else x_tag = (m_he != 0) ? "R8" : "R1 R11";
        end
      end
      m_hd = nd; m_hc = nc; m_he = ne;
    end
  endtask

  task automatic put(logic [31:0] d, logic [3:0] c, logic [3:0] e, bit al = 1, bit sr = 0);
    @(negedge clk);
    check_out();
    in_d = d; in_c = c; in_e = e; aligned = al; srst = sr;
    model(d, c, e, al, sr);
  endtask

  task automatic idle_col();
    put({8'h1C, 8'hBC, 8'h7C, 8'hBC}, 4'hF, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state at the ports
    n_run++;
    if (out_d !== {4{8'h07}} || out_c !== 4'hF) begin
      n_fail++;
      $display("FAIL R10: got %h/%b expected %h/%b", out_d, out_c, {4{8'h07}}, 4'hF);
    end
    rst_n = 1'b1;
    repeat (4) idle_col();

    // R2 R1 R4: clean frame, terminate in lane 2
    put(32'h443322FB, 4'b0001, 4'h0);
    put(32'h88776655, 4'h0, 4'h0);
    put(32'hCCBBAA99, 4'h0, 4'h0);
    put(32'hBCFD2211, 4'b1100, 4'h0);
    idle_col(); idle_col();

    // R3: start outside lane 0 and stray data are ignored
    put(32'h3322FB11, 4'b0010, 4'h0);
    put(32'h01020304, 4'h0, 4'h0);
    put(32'hBCBCFDBC, 4'hF, 4'h0);
    idle_col();

    // R6 then R2, R8 code error, R4 terminate in lane 0
    put(32'h0000019C, 4'b0001, 4'h0);
    put(32'h0A0B0CFB, 4'b0001, 4'h0);
    put(32'h11223344, 4'h0, 4'h0);
    put(32'h55667788, 4'h0, 4'b0100);
    put(32'hBCBCBCFD, 4'hF, 4'h0);
    idle_col(); idle_col();

    // R7: error character aborts; later columns ignored until start
    put(32'h777777FB, 4'b0001, 4'h0);
    put(32'h4433FE11, 4'b0010, 4'h0);
    put(32'h12121212, 4'h0, 4'h0);
    put(32'hBCBCFD12, 4'b1110, 4'h0);
    idle_col();

    // R5: data in the column after terminate
    put(32'h999999FB, 4'b0001, 4'h0);
    put(32'hBCBCFD10, 4'b1110, 4'h0);
    put(32'h12345678, 4'h0, 4'h0);
    idle_col();
    // R5: data after terminate inside its column
    put(32'h999999FB, 4'b0001, 4'h0);
    put(32'h22BCFD10, 4'b0110, 4'h0);
    idle_col(); idle_col();
    // R5: code error after terminate
    put(32'h999999FB, 4'b0001, 4'h0);
    put(32'hBCBCFD10, 4'b1110, 4'b0100);
    idle_col(); idle_col();

    // R9: alignment loss and synchronous clear drop the frame
    put(32'h313131FB, 4'b0001, 4'h0);
    put(32'h31313131, 4'h0, 4'h0);
    put(32'h32323232, 4'h0, 4'h0, 0, 0);
    put(32'h33333333, 4'h0, 4'h0);
    put(32'hBCBCBCFD, 4'hF, 4'h0);
    idle_col();
    put(32'h414141FB, 4'b0001, 4'h0);
    put(32'h42424242, 4'h0, 4'h0);
    put(32'h43434343, 4'h0, 4'h0, 1, 1);
    put(32'h44444444, 4'h0, 4'h0);
    idle_col(); idle_col();

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int r;
      int p;
      logic [31:0] d;
      logic [3:0] c;
      logic [3:0] e;
      r = int'($urandom_range(0, 99));
      d = $urandom;
      c = 4'h0;
      e = 4'h0;
      if (r < 28) begin
        d = {8'hBC, 8'h1C, 8'hBC, 8'h7C}; c = 4'hF;
      end else if (r < 38) begin
        d[7:0] = 8'hFB; c = 4'b0001;
      end else if (r < 72) begin
        c = 4'h0;
      end else if (r < 84) begin
        p = int'($urandom_range(0, 3));
        for (int i = 0; i < 4; i++) begin
          if (i == p) begin d[8*i +: 8] = 8'hFD; c[i] = 1'b1; end
          else if (i > p) begin d[8*i +: 8] = 8'hBC; c[i] = 1'b1; end
        end
        if ($urandom_range(0, 7) == 0) e[p] = 1'b1;
      end else if (r < 88) begin
        d[7:0] = 8'h9C; c = 4'b0001;
      end else if (r < 92) begin
        p = int'($urandom_range(0, 3));
        d[8*p +: 8] = 8'hFE; c[p] = 1'b1;
      end else if (r < 97) begin
        e[$urandom_range(0, 3)] = 1'b1;
      end
      put(d, c, e, (r != 97), (r == 98));
    end
    idle_col(); idle_col(); idle_col();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule